// File: doc/BRIEF.md
# System Clock Control and Prescaler

This block owns the 4-bit clock control word of a small 4-bit processor core and turns it into the core's system clock. Software loads the word from the accumulator with a write strobe and copies it back with a read strobe. The word picks the clock source, either the main clock or the slow sub-clock. It sets a divide ratio of 1, 2, 4 or 8, and it can shut the main oscillator down once the core is running from the sub-clock.

Everything runs in one fast sampling clock domain. Each oscillator arrives as a one-cycle tick input: one pulse per period of that oscillator. The block gates the two ticks through a glitch-free source switch. It then divides the gated tick stream and emits one system clock-enable pulse per divided period, so no generated clock is ever built.

A power-down request is granted only when the main clock is not an external clock input. The control word is not touched by power-down.

Top module: `sysclk_ctl`

## Requirements
- R1: After reset the control word reads 4'b1100 (mode 11, stop bit 0, source bit 0). The main source gate is on, the sub gate is off, the main oscillator enable is 1 and no system enable pulse is present.
- R2: A write strobe loads all four accumulator bits into the control word, apart from the stop-bit rule in R7. While the read strobe is high the read bus shows the word; while it is low the read bus is 0.
- R3: The mode field in bits 3:2 sets the ratio of gated source ticks to system enable pulses. Code 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8. A pulse appears in the cycle after the tick that completes a period.
- R4: A new mode is applied only at the next terminal count of the ratio currently in use. The period that is running finishes with its old length.
- R5: Bit 0 selects the source: 0 is main, 1 is sub. After the write edge that changes it, the old gate turns off 2 cycles later and the new gate turns on 2 cycles after that. The two gates are never on together.
- R6: Ticks from the source whose gate is off produce no system enable pulses.
- R7: Bit 1 is the oscillator stop bit. It is stored as 1 only when the written value has bit 0 = 1, the current word already has bit 0 = 1 and the main gate is off. Otherwise it is stored as 0, so the oscillator never stops while the main gate is on.
- R8: The main oscillator enable output is the inverse of the stored stop bit.
- R9: The power-down grant is high one cycle after a cycle in which the power-down request is high and the external-clock flag is low. In every other case the grant is low.
- R10: Power-down requests and grants leave the control word unchanged.
- R11: The divider count clears with reset. The first pulse after reset comes on the 8th main tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low reset |
| main_tick_i | input | 1 | One pulse per main oscillator period |
| sub_tick_i | input | 1 | One pulse per sub-clock period |
| wr_i | input | 1 | Control word write strobe |
| wdata_i | input | 4 | Accumulator value to write |
| rd_i | input | 1 | Control word read strobe |
| rdata_o | output | 4 | Control word onto the accumulator bus, 0 when not read |
| ext_clk_i | input | 1 | Main clock comes from an external clock input |
| pd_req_i | input | 1 | Power-down request |
| pd_grant_o | output | 1 | Power-down permitted |
| main_osc_en_o | output | 1 | Main oscillator run enable |
| src_main_o | output | 1 | Main source gate on |
| src_sub_o | output | 1 | Sub source gate on |
| sys_ce_o | output | 1 | System clock-enable pulse |

## Verification
Each result has a fixed latency after its stimulus:
- Read data is combinational, so it is checked in the cycle the read strobe is high.
- A system enable pulse is registered, so it is sampled on the falling edge after the tick that closes its period. Each pulse is credited to that tick's index.
- The source gates are sampled on each falling edge after a select write: the old gate is expected off after the 2nd edge and the new gate on after the 4th.
- The power-down grant and the oscillator enable are checked one edge after the input or write that sets them.

The register read-backs go through a queue that is compared at the cycle each read is due.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  typedef enum logic [1:0] {
    DIV1 = 2'b00,
    DIV2 = 2'b01,
    DIV4 = 2'b10,
    DIV8 = 2'b11
  } div_mode_e;

  typedef struct packed {
    div_mode_e mode;
    logic      osc_stop;
    logic      sel_sub;
  } ctl_reg_t;

  localparam ctl_reg_t CTL_RESET = '{mode: DIV8, osc_stop: 1'b0, sel_sub: 1'b0};
  localparam int       MODE_W    = $bits(div_mode_e);
endpackage

// File: rtl/clkctl_reg.sv
module clkctl_reg
  import clkctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [3:0] wdata_i,
  input  logic       rd_i,
  input  logic       main_gate_i,
  output ctl_reg_t   ctl_o,
  output logic [3:0] rdata_o
);
  ctl_reg_t ctl_q;
  ctl_reg_t wr_word;
  ctl_reg_t nxt;
  logic     stop_ok;

  assign wr_word = ctl_reg_t'(wdata_i);
  // stop only lands when the core already runs, and stays, on the sub-clock
  assign stop_ok = wr_word.sel_sub & ctl_q.sel_sub & ~main_gate_i;

  always_comb begin
    nxt          = wr_word;
    nxt.osc_stop = wr_word.osc_stop & stop_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctl_q <= CTL_RESET;
    else if (wr_i) ctl_q <= nxt;
  end

  assign ctl_o   = ctl_q;
  assign rdata_o = rd_i ? ctl_q : 4'b0000;
endmodule

// File: rtl/clkctl_srcsw.sv
module clkctl_srcsw #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_sub_i,
  input  logic main_tick_i,
  input  logic sub_tick_i,
  output logic main_gate_o,
  output logic sub_gate_o,
  output logic tick_o
);
  logic [SYNC_N-1:0] m_sync;
  logic [SYNC_N-1:0] s_sync;
  logic              m_req;
  logic              s_req;

  // each side asks to turn on only once the other side's gate is off
  assign m_req = ~sel_sub_i & ~s_sync[SYNC_N-1];
  assign s_req =  sel_sub_i & ~m_sync[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync <= '1;
      s_sync <= '0;
    end else begin
      m_sync <= {m_sync[SYNC_N-2:0], m_req};
      s_sync <= {s_sync[SYNC_N-2:0], s_req};
    end
  end

  assign main_gate_o = m_sync[SYNC_N-1];
  assign sub_gate_o  = s_sync[SYNC_N-1];
  assign tick_o      = (main_gate_o & main_tick_i) | (sub_gate_o & sub_tick_i);
endmodule

// File: rtl/clkctl_div.sv
module clkctl_div
  import clkctl_pkg::*;
#(
  parameter int MW = MODE_W
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_i,
  input  div_mode_e mode_i,
  output logic      ce_o
);
  localparam int NMODES = 1 << MW;
  localparam int CNT_W  = (NMODES > 1) ? NMODES - 1 : 1;

  div_mode_e        act_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;
  logic             at_term;

  assign term    = CNT_W'((1 << act_q) - 1);
  assign at_term = (cnt_q == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= DIV8;
      cnt_q <= '0;
      ce_o  <= 1'b0;
    end else begin
      ce_o <= tick_i & at_term;
      if (tick_i) begin
        if (at_term) begin
          cnt_q <= '0;
          act_q <= mode_i;  // ratio changes only on a period boundary
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sysclk_ctl.sv
module sysclk_ctl
  import clkctl_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       main_tick_i,
  input  logic       sub_tick_i,
  input  logic       wr_i,
  input  logic [3:0] wdata_i,
  input  logic       rd_i,
  output logic [3:0] rdata_o,
  input  logic       ext_clk_i,
  input  logic       pd_req_i,
  output logic       pd_grant_o,
  output logic       main_osc_en_o,
  output logic       src_main_o,
  output logic       src_sub_o,
  output logic       sys_ce_o
);
  ctl_reg_t   ctl;
  logic [3:0] ctl_q;
  logic       tick;

  clkctl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .wdata_i(wdata_i), .rd_i(rd_i),
    .main_gate_i(src_main_o), .ctl_o(ctl), .rdata_o(rdata_o)
  );

  clkctl_srcsw #(.SYNC_N(SYNC_N)) u_sw (
    .clk(clk), .rst_n(rst_n), .sel_sub_i(ctl.sel_sub),
    .main_tick_i(main_tick_i), .sub_tick_i(sub_tick_i),
    .main_gate_o(src_main_o), .sub_gate_o(src_sub_o), .tick_o(tick)
  );

  clkctl_div u_div (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_i(ctl.mode), .ce_o(sys_ce_o)
  );

  assign ctl_q         = ctl;
  assign main_osc_en_o = ~ctl.osc_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_grant_o <= 1'b0;
    else        pd_grant_o <= pd_req_i & ~ext_clk_i;
  end
endmodule

// File: rtl/sysclk_ctl_chk.sv
module sysclk_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_i,
  input logic       ext_clk_i,
  input logic       pd_req_i,
  input logic       pd_grant_o,
  input logic       main_osc_en_o,
  input logic       src_main_o,
  input logic       src_sub_o,
  input logic [3:0] ctl_q
);
  // R5
  gates_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_main_o && src_sub_o));

  // R5
  sub_after_main_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_sub_o) |-> !$past(src_main_o, 2));

  // R7
  osc_stop_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !main_osc_en_o |-> !src_main_o);

  // R9
  pd_grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_grant_o |-> ($past(pd_req_i) && !$past(ext_clk_i)));

  // R10
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_i) |-> $stable(ctl_q));
endmodule

bind sysclk_ctl sysclk_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .ext_clk_i(ext_clk_i),
  .pd_req_i(pd_req_i), .pd_grant_o(pd_grant_o), .main_osc_en_o(main_osc_en_o),
  .src_main_o(src_main_o), .src_sub_o(src_sub_o), .ctl_q(ctl_q)
);

// File: tb/sysclk_ctl_bench.sv
`timescale 1ns/1ps
module sysclk_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       main_tick_i = 1'b0, sub_tick_i = 1'b0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [3:0] wdata_i = 4'h0;
  logic [3:0] rdata_o;
  logic       ext_clk_i = 1'b0, pd_req_i = 1'b0;
  logic       pd_grant_o, main_osc_en_o, src_main_o, src_sub_o, sys_ce_o;

  int total = 0;
  int fails = 0;
  int exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  sysclk_ctl u_sysclk_ctl (
    .clk(clk), .rst_n(rst_n), .main_tick_i(main_tick_i), .sub_tick_i(sub_tick_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .rd_i(rd_i), .rdata_o(rdata_o),
    .ext_clk_i(ext_clk_i), .pd_req_i(pd_req_i), .pd_grant_o(pd_grant_o),
    .main_osc_en_o(main_osc_en_o), .src_main_o(src_main_o), .src_sub_o(src_sub_o),
    .sys_ce_o(sys_ce_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compares each read against the queued expectation
  always @(posedge clk) begin
    if (rd_i) begin
      #1;
      if (exp_q.size() > 0) begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata_o == 4'(e), t, int'(rdata_o), e);
      end
    end
  end

  task automatic do_write(input logic [3:0] d);
    @(negedge clk); wr_i = 1'b1; wdata_i = d;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] e, input string tag);
    @(negedge clk); rd_i = 1'b1;
    exp_q.push_back(int'(e)); tag_q.push_back(tag);
    @(negedge clk); rd_i = 1'b0;
  endtask

  task automatic run(input int n, input bit m_on, input bit s_on,
                     output int cnt, output int first);
    cnt = 0; first = 0;
    for (int i = 1; i <= n + 1; i++) begin
      @(negedge clk);
      if (i > 1 && sys_ce_o) begin
        cnt++;
        if (first == 0) first = i - 1;
      end
      main_tick_i = m_on && (i <= n);
      sub_tick_i  = s_on && (i <= n);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    int c, f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(src_main_o && !src_sub_o, "R1 gates", {src_main_o, src_sub_o}, 2);
    check(main_osc_en_o && !sys_ce_o, "R1 osc/ce", {main_osc_en_o, sys_ce_o}, 2);
    check(rdata_o == 4'h0, "R2 idle bus", int'(rdata_o), 0);
    do_read(4'b1100, "R1 reset word");
    // R7 stop write refused while main is in use
    do_write(4'b1110);
    do_read(4'b1100, "R7 refused stop");
    check(main_osc_en_o, "R8 osc on", main_osc_en_o, 1);
    // R11 first period after reset
    run(8, 1, 0, c, f);
    check(c == 1 && f == 8, "R11 first pulse", f, 8);
    // R4 then R3 divide by 2
    do_write(4'b0100);
    run(8, 1, 0, c, f);
    check(c == 1 && f == 8, "R4 old ratio kept", f, 8);
    run(8, 1, 0, c, f);
    check(c == 4 && f == 2, "R3 div2 count", c, 4);
    // through mode
    do_write(4'b0000);
    run(2, 1, 0, c, f);
    check(c == 1 && f == 2, "R4 div2 to div1", f, 2);
    run(6, 1, 0, c, f);
    check(c == 6 && f == 1, "R3 div1 count", c, 6);
    // divide by 4
    do_write(4'b1000);
    run(1, 1, 0, c, f);
    check(c == 1 && f == 1, "R4 div1 to div4", f, 1);
    run(8, 1, 0, c, f);
    check(c == 2 && f == 4, "R3 div4 count", c, 2);
    do_write(4'b0000);
    run(4, 1, 0, c, f);
    check(c == 1 && f == 4, "R4 div4 to div1", f, 4);
    // R6 sub ticks ignored on main
    run(6, 0, 1, c, f);
    check(c == 0, "R6 sub ignored", c, 0);
    // R5 switch to sub
    do_write(4'b0001);
    check(src_main_o && !src_sub_o, "R5 edge0", {src_main_o, src_sub_o}, 2);
    @(negedge clk);
    check(src_main_o && !src_sub_o, "R5 edge1", {src_main_o, src_sub_o}, 2);
    @(negedge clk);
    check(!src_main_o && !src_sub_o, "R5 edge2", {src_main_o, src_sub_o}, 0);
    @(negedge clk);
    check(!src_main_o && !src_sub_o, "R5 edge3", {src_main_o, src_sub_o}, 0);
    @(negedge clk);
    check(!src_main_o && src_sub_o, "R5 edge4", {src_main_o, src_sub_o}, 1);
    run(6, 1, 0, c, f);
    check(c == 0, "R6 main ignored", c, 0);
    run(5, 0, 1, c, f);
    check(c == 5 && f == 1, "R3 sub div1", c, 5);
    // R7/R8 stop accepted on sub
    do_write(4'b0011);
    check(!main_osc_en_o, "R8 osc off", main_osc_en_o, 0);
    do_read(4'b0011, "R2 word 0011");
    // R9 power-down gating
    @(negedge clk); pd_req_i = 1'b1; ext_clk_i = 1'b1;
    @(negedge clk);
    check(!pd_grant_o, "R9 ext blocks", pd_grant_o, 0);
    ext_clk_i = 1'b0;
    @(negedge clk);
    check(pd_grant_o, "R9 grant", pd_grant_o, 1);
    pd_req_i = 1'b0;
    @(negedge clk);
    check(!pd_grant_o, "R9 release", pd_grant_o, 0);
    do_read(4'b0011, "R10 word kept");
    // back to main, stop bit dropped
    do_write(4'b0110);
    repeat (4) @(negedge clk);
    check(src_main_o && !src_sub_o, "R5 back to main", {src_main_o, src_sub_o}, 2);
    check(main_osc_en_o, "R7 stop cleared", main_osc_en_o, 1);
    do_read(4'b0100, "R7 word 0100");
    run(4, 1, 0, c, f);
    check(c == 2 && f == 1, "R4 div1 to div2", c, 2);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule